// File: doc/BRIEF.md
# Command/Response FIFO Status Engine

This block is the host-facing command path of a security coprocessor page. Software loads a command one byte at a time through a byte-wide data port. It watches a status byte and a 16-bit burst count to know how many bytes it may move without waiting. Once the whole command is loaded, software writes the go bit. The engine then streams the stored command to an execution backend and collects the backend's response into the same storage. Completion is shown to software as data-available, and software then drains the response through the same data port.

The expected command length is not programmed separately. The engine takes it from a big-endian 32-bit size field at byte positions 2 to 5 of the 10-byte header that opens every command. The response length is found the same way, from the response header. A write of the command-ready bit aborts whatever is in progress, at any point, and returns the engine to its idle ready state.

Top module: `cmd_fifo_engine`

## Requirements
- R1: After reset the status byte reads 0xC0 (status-valid and command-ready set) and the burst count reads DEPTH (64: low byte 0x40, high byte 0x00).
- R2: Status byte layout (offset 0x18): bit 7 status-valid (always 1), bit 6 command-ready (idle state only), bit 5 go (reads 0), bit 4 data-available, bit 3 data-expected, bit 2 sticky overflow, bits 1..0 zero.
- R3: The burst count reads at offset 0x19 (low byte) and 0x1A (high byte). It equals DEPTH minus the bytes held while idle or loading, 0 while the backend is working, and the number of unread response bytes while draining.
- R4: Data-expected is 1 from the first command byte until the command length has been written. That length is the big-endian value in header bytes 2..5, raised to 10 if smaller and lowered to DEPTH if larger. Data-expected falls to 0 once the final byte has been written.
- R5: A data write while loading with data-expected at 0 is dropped, leaves the burst count unchanged and sets the overflow bit. The overflow bit stays set until a command-ready write.
- R6: A go write while loading with data-expected at 0 starts execution. A go write while data-expected is 1 is ignored.
- R7: During execution the stored command bytes are offered in order on cmd_valid/cmd_data, and each one moves on when cmd_ready is high; cmd_last marks the final byte.
- R8: After the command has been sent, rsp_ready accepts response bytes until the response length has been received. That length is taken from response header bytes 2..5 with the same limits as in R4. rsp_ready then drops.
- R9: Once the response is held, data-available and status-valid read 1. Data-port reads (offset 0x24) return the response bytes in order, and data-available falls after the last one. A data read with nothing available returns 0xFF and has no effect.
- R10: A status write with bit 6 set returns the engine to the idle ready state from any state, clearing the stored bytes and the overflow flag. It takes priority over a go bit set in the same write.
- R11: Data-port writes during execution or draining are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW | Byte offset of the access within the page |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe; a data-port read pops a byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| cmd_valid | output | 1 | Command byte offered to the backend |
| cmd_data | output | 8 | Command byte |
| cmd_last | output | 1 | Offered byte is the final command byte |
| cmd_ready | input | 1 | Backend takes the offered byte |
| rsp_valid | input | 1 | Backend offers a response byte |
| rsp_data | input | 8 | Response byte |
| rsp_ready | output | 1 | Engine accepts the offered response byte |

## Verification
The embedded assertions watch, on every cycle, that a command-ready write always lands in the idle state with a full burst count, that an early go never leaves the loading state, that the overflow bit stays set, that command-ready, data-available, data-expected and the two backend handshakes are never active together, and that each response pop lowers the burst count by exactly one. Only the directed scenarios can show that the length is decoded from the right header bytes with its clamping, that the command reaches the backend byte for byte, that the response comes back out in order, and that dropped or ignored bytes leave the visible state untouched.

// File: rtl/cmd_fifo_engine.sv
module cmd_fifo_engine #(
  parameter int DEPTH    = 64,
  parameter int HDR      = 10,
  parameter int AW       = 12,
  parameter int STS_OFS  = 'h018,
  parameter int FIFO_OFS = 'h024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic          cmd_valid,
  output logic [7:0]    cmd_data,
  output logic          cmd_last,
  input  logic          cmd_ready,
  input  logic          rsp_valid,
  input  logic [7:0]    rsp_data,
  output logic          rsp_ready
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [CW-1:0] HDR_C   = CW'(HDR);
  localparam logic [AW-1:0] A_STS   = AW'(STS_OFS);
  localparam logic [AW-1:0] A_BC0   = AW'(STS_OFS + 1);
  localparam logic [AW-1:0] A_BC1   = AW'(STS_OFS + 2);
  localparam logic [AW-1:0] A_FIFO  = AW'(FIFO_OFS);

  typedef enum logic [2:0] {S_READY, S_RECV, S_SEND, S_COLLECT, S_DONE} st_t;

  st_t            st;
  logic [CW-1:0]  cnt, ptr, eff;
  logic [31:0]    len32;
  logic           ovf;
  logic [7:0]     mem [DEPTH];

  logic wr_sts, abort, go, wr_fifo, rd_fifo;
  logic need_more, avail, expect_f;
  logic buf_we;
  logic [7:0] buf_wd, sts_byte;
  logic [15:0] burst;

  assign wr_sts  = bus_wr && bus_addr == A_STS;
  assign abort   = wr_sts && bus_wdata[6];
  assign go      = wr_sts && bus_wdata[5] && !bus_wdata[6];
  assign wr_fifo = bus_wr && bus_addr == A_FIFO;
  assign rd_fifo = bus_rd && bus_addr == A_FIFO;

  always_comb begin
    if ((|len32[31:CW]) || len32[CW-1:0] > DEPTH_C) eff = DEPTH_C;
    else if (len32[CW-1:0] < HDR_C)                 eff = HDR_C;
    else                                            eff = len32[CW-1:0];
  end

  assign need_more = (cnt < HDR_C) || (cnt < eff);
  assign avail     = st == S_DONE && ptr < cnt;
  assign expect_f  = st == S_RECV && need_more;

  assign cmd_valid = st == S_SEND;
  assign cmd_data  = mem[ptr[IW-1:0]];
  assign cmd_last  = st == S_SEND && ptr == cnt - CW'(1);
  assign rsp_ready = st == S_COLLECT && need_more;

  assign buf_we = (st == S_READY && wr_fifo) ||
                  (st == S_RECV && wr_fifo && need_more) ||
                  (st == S_COLLECT && rsp_valid && rsp_ready);
  assign buf_wd = (st == S_COLLECT) ? rsp_data : bus_wdata;

  always_ff @(posedge clk)
    if (buf_we) mem[cnt[IW-1:0]] <= buf_wd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_READY; cnt <= '0; ptr <= '0; len32 <= '0; ovf <= 1'b0;
    end else if (abort) begin
      st <= S_READY; cnt <= '0; ptr <= '0; len32 <= '0; ovf <= 1'b0;
    end else begin
      if (buf_we) begin
        cnt <= cnt + CW'(1);
        if (cnt >= CW'(2) && cnt <= CW'(5)) len32 <= {len32[23:0], buf_wd};
      end
      case (st)
        S_READY:   if (wr_fifo) st <= S_RECV;
        S_RECV: begin
          if (wr_fifo && !need_more) ovf <= 1'b1;
          if (go && !need_more) begin
            st  <= S_SEND;
            ptr <= '0;
          end
        end
        S_SEND:
          if (cmd_ready) begin
            ptr <= ptr + CW'(1);
            if (cmd_last) begin
              st <= S_COLLECT; cnt <= '0; ptr <= '0;
            end
          end
        S_COLLECT:
          if (!need_more) begin
            st  <= S_DONE;
            ptr <= '0;
          end
        S_DONE:    if (rd_fifo && avail) ptr <= ptr + CW'(1);
        default:   st <= S_READY;
      endcase
    end
  end

  always_comb begin
    case (st)
      S_READY: burst = 16'(DEPTH_C);
      S_RECV:  burst = 16'(DEPTH_C - cnt);
      S_DONE:  burst = 16'(cnt - ptr);
      default: burst = 16'd0;
    endcase
  end

  assign sts_byte = {1'b1, st == S_READY, 1'b0, avail, expect_f, ovf, 2'b00};

  always_comb begin
    if (bus_addr == A_STS)       bus_rdata = sts_byte;
    else if (bus_addr == A_BC0)  bus_rdata = burst[7:0];
    else if (bus_addr == A_BC1)  bus_rdata = burst[15:8];
    else if (bus_addr == A_FIFO) bus_rdata = avail ? mem[ptr[IW-1:0]] : 8'hFF;
    else                         bus_rdata = 8'hFF;
  end

  a_r10_abort_ready: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (sts_byte[6] && burst == 16'(DEPTH)));

  a_r6_early_go: assert property (@(posedge clk) disable iff (!rst_n)
    (go && expect_f) |=> (st == S_RECV && !cmd_valid));

  a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !abort) |=> ovf);

  a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sts_byte[6], avail, expect_f, cmd_valid, rsp_ready}));

  a_r9_pop_count: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fifo && avail && !abort) |=> burst == $past(burst) - 16'd1);

  a_r3_burst_bound: assert property (@(posedge clk) disable iff (!rst_n)
    burst <= 16'(DEPTH));
endmodule

// File: tb/cmd_fifo_engine_test.sv
module cmd_fifo_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] STS = 12'h018, BC0 = 12'h019, BC1 = 12'h01A, FIFO = 12'h024;

  logic clk = 0, rst_n = 0;
  logic [11:0] bus_addr = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic cmd_valid, cmd_last, cmd_ready = 0;
  logic [7:0] cmd_data;
  logic rsp_valid = 0, rsp_ready;
  logic [7:0] rsp_data = '0;

  int checks = 0, errors = 0;
  logic [7:0] cmdb [64];
  logic [7:0] rspb [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_fifo_engine uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmd_valid(cmd_valid),
    .cmd_data(cmd_data), .cmd_last(cmd_last), .cmd_ready(cmd_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ready(rsp_ready));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic expect_reg(input logic [11:0] a, input logic [7:0] e, input string req);
    logic [7:0] v;
    rd(a, v);
    chk(v == e, req, v, e);
  endtask

  task automatic build_cmd(input int n, input logic [31:0] len);
    for (int i = 0; i < n; i++) cmdb[i] = 8'(i * 7 + 3);
    cmdb[2] = len[31:24]; cmdb[3] = len[23:16]; cmdb[4] = len[15:8]; cmdb[5] = len[7:0];
  endtask

  task automatic load(input int from, input int to);
    for (int i = from; i < to; i++) wr(FIFO, cmdb[i]);
  endtask

  task automatic serve_cmd(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cmd_ready = 1; #1;
      chk(cmd_valid && cmd_data == cmdb[i] && cmd_last == (i == n - 1),
          "R7 command byte", cmd_data, cmdb[i]);
    end
    @(negedge clk); cmd_ready = 0; #1;
    chk(!cmd_valid, "R7 stream ends", cmd_valid, 0);
  endtask

  task automatic serve_rsp(input int m);
    for (int j = 0; j < m; j++) begin
      @(negedge clk); rsp_valid = 1; rsp_data = rspb[j]; #1;
      chk(rsp_ready, "R8 rsp_ready while collecting", rsp_ready, 1);
    end
    @(negedge clk); rsp_valid = 0; #1;
    chk(!rsp_ready, "R8 rsp_ready drops at length", rsp_ready, 0);
  endtask

  task automatic t_reset;
    expect_reg(STS, 8'hC0, "R1 reset status");
    expect_reg(BC0, 8'h40, "R1 reset burst low");
    expect_reg(BC1, 8'h00, "R1 reset burst high");
  endtask

  task automatic t_full_flow;
    logic [7:0] v;
    wr(STS, 8'h40);
    build_cmd(12, 32'd12);
    load(0, 1);
    expect_reg(STS, 8'h88, "R2 loading status fields");
    expect_reg(BC0, 8'd63, "R3 free space while loading");
    load(1, 11);
    expect_reg(STS, 8'h88, "R4 expect held before final byte");
    wr(STS, 8'h20);
    #1 chk(!cmd_valid, "R6 early go ignored", cmd_valid, 0);
    expect_reg(STS, 8'h88, "R6 state after early go");
    load(11, 12);
    expect_reg(STS, 8'h80, "R4 expect falls after final byte");
    wr(STS, 8'h20);
    expect_reg(BC0, 8'h00, "R3 burst zero while executing");
    serve_cmd(12);
    for (int j = 0; j < 11; j++) rspb[j] = 8'(8'hA0 + j);
    rspb[2] = 0; rspb[3] = 0; rspb[4] = 0; rspb[5] = 8'd11;
    serve_rsp(11);
    expect_reg(STS, 8'h90, "R9 completion status");
    expect_reg(BC0, 8'd11, "R3 remaining response bytes");
    for (int j = 0; j < 11; j++) begin
      rd(FIFO, v);
      chk(v == rspb[j], "R9 response byte order", v, rspb[j]);
    end
    expect_reg(STS, 8'h80, "R9 data-available falls after last byte");
    expect_reg(FIFO, 8'hFF, "R9 empty read value");
    expect_reg(BC0, 8'h00, "R9 empty read has no effect");
    wr(FIFO, 8'h55);
    expect_reg(STS, 8'h80, "R11 write while draining ignored");
    expect_reg(BC0, 8'h00, "R11 burst unchanged");
    wr(STS, 8'h40);
    expect_reg(STS, 8'hC0, "R10 abort from completed state");
  endtask

  task automatic t_overflow;
    build_cmd(10, 32'd10);
    load(0, 10);
    expect_reg(STS, 8'h80, "R4 ten byte command complete");
    wr(FIFO, 8'hEE);
    expect_reg(STS, 8'h84, "R5 overflow flag set");
    expect_reg(BC0, 8'd54, "R5 extra byte dropped");
    wr(FIFO, 8'hEF);
    expect_reg(STS, 8'h84, "R5 overflow flag sticky");
    wr(STS, 8'h40);
    expect_reg(STS, 8'hC0, "R5 overflow cleared by command-ready");
  endtask

  task automatic t_clamp;
    build_cmd(64, 32'h0000_0100);
    load(0, 63);
    expect_reg(STS, 8'h88, "R4 oversized length clamps to depth");
    load(63, 64);
    expect_reg(STS, 8'h80, "R4 clamped command complete");
    expect_reg(BC0, 8'h00, "R3 no free space at depth");
    wr(STS, 8'h40);
    build_cmd(10, 32'd3);
    load(0, 9);
    expect_reg(STS, 8'h88, "R4 short length raised to header size");
    load(9, 10);
    expect_reg(STS, 8'h80, "R4 header-size command complete");
    wr(STS, 8'h40);
  endtask

  task automatic t_abort;
    build_cmd(10, 32'd10);
    load(0, 10);
    wr(STS, 8'h60);
    #1 chk(!cmd_valid, "R10 command-ready wins over go", cmd_valid, 0);
    expect_reg(STS, 8'hC0, "R10 abort with go in same write");
    load(0, 10);
    wr(STS, 8'h20);
    #1 chk(cmd_valid && cmd_data == cmdb[0], "R6 go starts execution", cmd_data, cmdb[0]);
    wr(FIFO, 8'h11);
    expect_reg(BC0, 8'h00, "R11 write during execution ignored");
    wr(STS, 8'h40);
    #1 chk(!cmd_valid, "R10 abort during execution", cmd_valid, 0);
    expect_reg(STS, 8'hC0, "R10 ready after abort");
    expect_reg(BC0, 8'h40, "R10 storage cleared");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_full_flow();
    t_overflow();
    t_clamp();
    t_abort();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule